// File: doc/BRIEF.md
# Next Program Counter Unit

This block keeps the program counter of a simple single-issue processor and decides, once per clock, where the next instruction is fetched from. It holds a 32-bit address register. Around that register it builds three candidate next addresses: the sequential address, a relative branch target and an absolute jump target. It picks one of them from the control flags of the instruction at the current address. The instruction fields (a 16-bit displacement and a 26-bit jump field), the branch and jump flags, and the ALU zero flag all arrive as inputs. Fetch memory, operand storage and the ALU itself sit outside this block.

The selection works like a small decision machine with three named cases. SRC_SEQ (fall through) is chosen when neither a jump nor a taken branch is present. SRC_BRANCH (taken branch) is chosen when the branch flag and the zero flag are both high and there is no jump. SRC_JUMP (jump) is chosen whenever the jump flag is high. Each clock moves the register from its current address to the address of the chosen case. A synchronous reset moves it to address 0 from any case.

The current address and the sequential address are both exported, so the fetch side and any link-address logic can use them directly.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` becomes 0 after that edge, whatever the other inputs are.
- R2: When `jump_i` is 0 and (`branch_i` AND `zero_i`) is 0, `pc_o` after the edge equals the old `pc_o` + 4.
- R3: `pc_plus4_o` always equals `pc_o` + 4 modulo 2^32, without waiting for a clock edge.
- R4: When `branch_i` = 1, `zero_i` = 1 and `jump_i` = 0, `pc_o` after the edge equals old `pc_o` + 4 + (the sign-extended `imm_i` multiplied by 4). The sign extension copies bit 15 of `imm_i` into bits 31..18 of the offset, and offset bits 1..0 are 0.
- R5: A branch whose condition is false (`branch_i` = 1, `zero_i` = 0) falls through to `pc_o` + 4. The value of `zero_i` has no effect when `branch_i` = 0.
- R6: A negative displacement (bit 15 of `imm_i` set) moves the address backwards. For example, `imm_i` = 16'hFFFF makes a taken branch return to its own address.
- R7: When `jump_i` = 1, `pc_o` after the edge equals {bits 31..28 of (old `pc_o` + 4), `tgt_i`, 2'b00}.
- R8: If `jump_i` = 1 in the same cycle as a taken branch, the jump target wins.
- R9: Address arithmetic wraps modulo 2^32. Falling through from 32'hFFFFFFFC gives 0, and a branch below address 0 wraps to the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imm_i | input | 16 | Branch displacement in words, two's complement |
| tgt_i | input | 26 | Jump word-address field |
| branch_i | input | 1 | Current instruction is a conditional branch |
| jump_i | input | 1 | Current instruction is an unconditional jump |
| zero_i | input | 1 | ALU zero result (branch condition true) |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current program counter plus 4 |

## Verification
A jump and a taken branch can be asserted in the same cycle, and the priority rule (R8) decides between them. The bench provokes this collision with a directed case that raises the jump flag, the branch flag and the zero flag together with distinct displacement and target fields. The random phase also produces the same collision many times. In each case the next address is judged against the jump target, which the bench computes itself, and never against the branch target.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Instructions are word aligned: two zero bits below every address.
    localparam int ALIGN_BITS = 2;

    // The three selection cases for the next address.
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } npc_src_e;

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int W     = 32,
    parameter int ALIGN = 2
) (
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] seq_o
);
    // One instruction word, in bytes.
    localparam logic [W-1:0] STEP = W'(1) << ALIGN;

    // Any carry out of the top bit is dropped, so the sum wraps modulo 2^W.
    assign seq_o = pc_i + STEP;

endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int ALIGN = 2
) (
    input  logic [W-1:0]     base_i,
    input  logic [IMM_W-1:0] disp_i,
    output logic [W-1:0]     tgt_o
);
    logic [W-1:0] offs;

    // The offset is built from wiring alone. Bits below ALIGN are zero,
    // the middle bits are the displacement, and every bit above it is a
    // copy of the displacement's sign bit.
    for (genvar i = 0; i < W; i++) begin : g_ext
        if (i < ALIGN) begin : g_low
            assign offs[i] = 1'b0;
        end else if (i - ALIGN < IMM_W) begin : g_mid
            assign offs[i] = disp_i[i-ALIGN];
        end else begin : g_sign
            assign offs[i] = disp_i[IMM_W-1];
        end
    end

    assign tgt_o = base_i + offs;

endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
    parameter int W     = 32,
    parameter int TGT_W = 26,
    parameter int ALIGN = 2
) (
    input  logic [W-1:0]     base_i,
    input  logic [TGT_W-1:0] field_i,
    output logic [W-1:0]     tgt_o
);
    // Number of upper address bits kept from the base address.
    localparam int HI_W = W - TGT_W - ALIGN;

    assign tgt_o = {base_i[W-1 -: HI_W], field_i, {ALIGN{1'b0}}};

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         branch_i,
    input  logic         zero_i,
    input  logic         jump_i,
    input  logic [W-1:0] seq_i,
    input  logic [W-1:0] br_i,
    input  logic [W-1:0] jmp_i,
    output logic [W-1:0] next_o
);
    npc_src_e src;
    logic     taken;

    // Case decision. A jump always wins. Otherwise the branch target is
    // used only when the branch flag and the zero flag are both high.
    always_comb begin
        taken = branch_i & zero_i;
        if (jump_i) begin
            src = SRC_JUMP;
        end else if (taken) begin
            src = SRC_BRANCH;
        end else begin
            src = SRC_SEQ;
        end
    end

    // Output multiplexer, steered only by the decided case.
    always_comb begin
        unique case (src)
            SRC_SEQ:    next_o = seq_i;
            SRC_BRANCH: next_o = br_i;
            SRC_JUMP:   next_o = jmp_i;
            default:    next_o = seq_i;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          IMM_W    = 16,
    parameter int          TGT_W    = 26,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [TGT_W-1:0]  tgt_i,
    input  logic              branch_i,
    input  logic              jump_i,
    input  logic              zero_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_plus4_o
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;
    logic [ADDR_W-1:0] next_addr;

    npc_incr #(.W(ADDR_W), .ALIGN(ALIGN_BITS)) u_incr (
        .pc_i  (pc_q),
        .seq_o (seq_addr)
    );

    npc_branch_tgt #(.W(ADDR_W), .IMM_W(IMM_W), .ALIGN(ALIGN_BITS)) u_br (
        .base_i (seq_addr),
        .disp_i (imm_i),
        .tgt_o  (br_addr)
    );

    npc_jump_tgt #(.W(ADDR_W), .TGT_W(TGT_W), .ALIGN(ALIGN_BITS)) u_jmp (
        .base_i  (seq_addr),
        .field_i (tgt_i),
        .tgt_o   (jmp_addr)
    );

    npc_select #(.W(ADDR_W)) u_sel (
        .branch_i (branch_i),
        .zero_i   (zero_i),
        .jump_i   (jump_i),
        .seq_i    (seq_addr),
        .br_i     (br_addr),
        .jmp_i    (jmp_addr),
        .next_o   (next_addr)
    );

    // Address register: loads exactly one new value per clock.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= ADDR_W'(RESET_PC);
        end else begin
            pc_q <= next_addr;
        end
    end

    assign pc_o       = pc_q;
    assign pc_plus4_o = seq_addr;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int TGT_W  = 26
) (
    input logic              clk,
    input logic              rst,
    input logic [IMM_W-1:0]  imm_i,
    input logic [TGT_W-1:0]  tgt_i,
    input logic              branch_i,
    input logic              jump_i,
    input logic              zero_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] pc_plus4_o
);
    localparam int AL    = 2;
    localparam int EXT_W = ADDR_W - IMM_W - AL;
    localparam int HI_W  = ADDR_W - TGT_W - AL;

    // R1: reset returns the register to address zero.
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (pc_o == '0));

    // R3: the exported sequential address tracks the register.
    p_plus4_track_r3: assert property (@(posedge clk) disable iff (rst)
        pc_plus4_o == pc_o + ADDR_W'(4));

    // R2 / R5: with no jump and no taken branch, the next address is the
    // sequential one.
    p_fall_through_r2: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && !(branch_i && zero_i)) |=> (pc_o == $past(pc_plus4_o)));

    // R4 / R6: a taken branch adds the sign-extended, word-scaled offset.
    p_branch_target_r4: assert property (@(posedge clk) disable iff (rst)
        (branch_i && zero_i && !jump_i) |=>
        (pc_o == $past(pc_plus4_o)
                 + $past({{EXT_W{imm_i[IMM_W-1]}}, imm_i, {AL{1'b0}}})));

    // R7 / R8: a jump always lands on its absolute target.
    p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
        jump_i |=>
        (pc_o == {$past(pc_plus4_o[ADDR_W-1 -: HI_W]), $past(tgt_i), {AL{1'b0}}}));

endmodule

bind npc_unit npc_unit_chk #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .TGT_W  (TGT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .imm_i      (imm_i),
    .tgt_i      (tgt_i),
    .branch_i   (branch_i),
    .jump_i     (jump_i),
    .zero_i     (zero_i),
    .pc_o       (pc_o),
    .pc_plus4_o (pc_plus4_o)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] imm;
    logic [25:0] tgt;
    logic        br, jp, zr;
    logic [31:0] pc, pc4;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] exp_pc;

    always #4 clk = ~clk;  // 125 MHz

    npc_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .imm_i      (imm),
        .tgt_i      (tgt),
        .branch_i   (br),
        .jump_i     (jp),
        .zero_i     (zr),
        .pc_o       (pc),
        .pc_plus4_o (pc4)
    );

    // Reference model of the next address, written from the requirements.
    function automatic logic [31:0] model_next(
        input logic [31:0] cur, input logic [15:0] d, input logic [25:0] t,
        input logic b, input logic j, input logic z, input logic r);
        logic [31:0] seq;
        logic [31:0] offs;
        seq  = cur + 32'd4;
        offs = 32'(signed'(d)) * 32'sd4;
        if (r)          return 32'h0;
        if (j)          return {seq[31:28], t, 2'b00};
        if (b && z)     return seq + offs;
        return seq;
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic step(input logic [15:0] d, input logic [25:0] t,
                        input logic b, input logic j, input logic z,
                        input logic r, input string tag);
        logic [31:0] nxt;
        @(negedge clk);
        imm = d; tgt = t; br = b; jp = j; zr = z; rst = r;
        nxt = model_next(exp_pc, d, t, b, j, z, r);
        @(posedge clk);
        #1;
        check(tag, pc, nxt);
        check("R3", pc4, nxt + 32'd4);
        exp_pc = nxt;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; imm = '0; tgt = '0; br = 0; jp = 0; zr = 0;
        exp_pc = '0;
        void'($urandom(32'h5EED_0042));
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R1", pc, 32'h0);
        check("R3", pc4, 32'h4);

        step(16'h0000, 26'h0, 0, 0, 0, 0, "R2");       // fall through
        step(16'h0005, 26'h0, 1, 0, 0, 0, "R5");       // branch, condition false
        step(16'h0007, 26'h0, 0, 0, 1, 0, "R5");       // zero without branch
        step(16'h0003, 26'h0, 1, 0, 1, 0, "R4");       // taken forward
        step(16'hFFFF, 26'h0, 1, 0, 1, 0, "R6");       // taken to own address
        check("R6", pc, exp_pc);
        step(16'h0000, 26'h0ABCDEF, 0, 1, 0, 0, "R7"); // jump
        step(16'h0010, 26'h0123456, 1, 1, 1, 0, "R8"); // jump beats branch
        step(16'h0000, 26'h3FFFFFF, 0, 1, 0, 1, "R1"); // reset beats jump
        step(16'hFFFE, 26'h0, 1, 0, 1, 0, "R9");       // 4-8 wraps to top
        check("R9", pc, 32'hFFFF_FFFC);
        step(16'h0000, 26'h0, 0, 0, 0, 0, "R9");       // top + 4 wraps to 0
        check("R9", pc, 32'h0);
        step(16'hFFFD, 26'h0, 1, 0, 1, 0, "R6");       // 4-12 -> FFFFFFF8
        step(16'h0000, 26'h0000005, 0, 1, 0, 0, "R7"); // upper nibble from pc+4
        check("R7", pc, 32'hF000_0014);

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            logic [25:0] t;
            logic b, j, z, r;
            string tag;
            d = 16'($urandom);
            t = 26'($urandom);
            b = ($urandom % 100) < 35;
            j = ($urandom % 100) < 15;
            z = ($urandom % 2) == 1;
            r = ($urandom % 100) == 0;
            if (r)               tag = "R1";
            else if (j && b && z) tag = "R8";
            else if (j)          tag = "R7";
            else if (b && z)     tag = "R4";
            else if (b)          tag = "R5";
            else                 tag = "R2";
            step(d, t, b, j, z, r, tag);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule